// File: doc/BRIEF.md
# Dual Wiper Position Controller with Shutdown

This block holds the digital state behind a pair of 256-step resistor dividers. It keeps two wiper code registers and one control register, and it drives the switch controls of each array. For every channel it produces a one-hot tap select, an end-open control and a wiper clamp control. An upstream serial bus slave writes and reads the registers through a simple address/data port. The analog array and the bus protocol engine sit outside this block.

A change of wiper code never leaves the wiper floating. For a fixed number of clocks the old and the new tap switches are both closed, and only then is the old one released. If another code arrives during that window, it waits and gets its own overlap window afterwards. A single active-low enable bit in the control register puts both channels into a low-power state. In that state the array ends are opened and the wiper is clamped toward the low end. The stored codes survive this state, unless a supply glitch is reported during it. On leaving the state, each channel waits out a settling period before it reconnects the tap.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: After power-on reset both wiper registers read 80h, the control register reads 40h, each channel selects tap 128 alone, and the open and clamp controls are low.
- R2: Register addresses are 00h (channel 0 code), 01h (channel 1 code) and 10h (control). Reads are combinational and return stored values. A write to any other address changes nothing, and a read of it returns 00h.
- R3: Only control bit 6 (run enable, active high, so 0 means shutdown) is writable. All other control bits read 0.
- R4: In steady operation a channel's select bus has exactly one bit set, at the index equal to its code: code 00h drives bit 0 and code FFh drives bit 255.
- R5: One clock after a code register changes, the channel drives both the old and the new select bits for OVERLAP clocks. After that only the new bit remains.
- R6: A code written while an overlap window is running leaves the outputs unaffected until that window ends. The channel then runs a new overlap window from the current tap to the queued code.
- R7: One clock after bit 6 is cleared, both channels drop every tap select and raise both open and clamp controls.
- R8: Code writes during shutdown are stored and read back at once, but they select no tap while shutdown lasts.
- R9: One clock after bit 6 is set again, the open controls fall, the clamp stays high and no tap is selected for SETTLE clocks. Then the clamp falls and the stored code's tap is selected alone.
- R10: A glitch pulse sampled while in shutdown loads 80h into both code registers, and it overrides a write in the same cycle. A glitch sampled while running changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| glitch | input | 1 | Supply-glitch indication, sampled each clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| tap_sel0 | output | 256 | One-hot tap switch controls, channel 0 |
| tap_sel1 | output | 256 | One-hot tap switch controls, channel 1 |
| open_ends | output | 2 | Per channel: open the array end-to-end |
| clamp_low | output | 2 | Per channel: tie wiper to low end through series resistor |

## Verification
Suppose a channel's applied code drifts away from its stored code. The select bus then differs from the one-hot of the read-back value. That shows up at most OVERLAP+1 clocks after the last write, or SETTLE+1 clocks after leaving shutdown. A stuck sequencing state shows up differently. Either the select bus keeps two bits past the overlap window, or it stays empty while the clamp is already low, and both are visible on the ports within the clock that follows the window. Lost or wrongly reset code registers show up at once on the combinational read port.

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl #(
  parameter int CODE_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int OVERLAP = 4,
  parameter int SETTLE  = 6
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   glitch,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CODE_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [CODE_W-1:0]      rd_data,
  output logic [(1<<CODE_W)-1:0] tap_sel0,
  output logic [(1<<CODE_W)-1:0] tap_sel1,
  output logic [1:0]             open_ends,
  output logic [1:0]             clamp_low
);
  localparam int NTAP = 1 << CODE_W;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W-1);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(16);
  localparam int RUN_BIT = 6;
  localparam int CMAX = (OVERLAP > SETTLE) ? OVERLAP : SETTLE;
  localparam int CW = $clog2(CMAX + 1);

  typedef enum logic [1:0] {ST_HOLD, ST_OVL, ST_OFF, ST_SETTLE} ch_st_e;

  logic [CODE_W-1:0] wiper_q [2];
  logic              run_q;
  logic [NTAP-1:0]   sel [2];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_q <= 1'b1;
      for (int c = 0; c < 2; c++) wiper_q[c] <= MID;
    end else begin
      if (wr_en && wr_addr == CTRL_ADDR) run_q <= wr_data[RUN_BIT];
      for (int c = 0; c < 2; c++) begin
        if (glitch && !run_q)
          wiper_q[c] <= MID;
        else if (wr_en && wr_addr == ADDR_W'(c))
          wiper_q[c] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(0))      rd_data = wiper_q[0];
    else if (rd_addr == ADDR_W'(1)) rd_data = wiper_q[1];
    else if (rd_addr == CTRL_ADDR)  rd_data[RUN_BIT] = run_q;
  end

  for (genvar i = 0; i < 2; i++) begin : g_ch
    ch_st_e            st_q;
    logic [CODE_W-1:0] cur_q, prev_q;
    logic [CW-1:0]     cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        st_q   <= ST_HOLD;
        cur_q  <= MID;
        prev_q <= MID;
        cnt_q  <= '0;
      end else if (!run_q) begin
        st_q <= ST_OFF;
      end else begin
        unique case (st_q)
          ST_OFF: begin
            st_q  <= ST_SETTLE;
            cur_q <= wiper_q[i];
            cnt_q <= CW'(SETTLE - 1);
          end
          ST_SETTLE, ST_OVL: begin
            if (cnt_q == '0) st_q <= ST_HOLD;
            else             cnt_q <= cnt_q - 1'b1;
          end
          ST_HOLD: begin
            if (wiper_q[i] != cur_q) begin
              prev_q <= cur_q;
              cur_q  <= wiper_q[i];
              cnt_q  <= CW'(OVERLAP - 1);
              st_q   <= ST_OVL;
            end
          end
          default: st_q <= ST_HOLD;
        endcase
      end
    end

    assign sel[i] = (st_q == ST_HOLD) ? (NTAP'(1) << cur_q) :
                    (st_q == ST_OVL)  ? ((NTAP'(1) << cur_q) | (NTAP'(1) << prev_q)) :
                    '0;
    assign open_ends[i] = (st_q == ST_OFF);
    assign clamp_low[i] = (st_q == ST_OFF) || (st_q == ST_SETTLE);
  end

  assign tap_sel0 = sel[0];
  assign tap_sel1 = sel[1];
endmodule

// File: rtl/dual_wiper_ctrl_chk.sv
module dual_wiper_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic                   clk,
  input logic                   por_n,
  input logic                   glitch,
  input logic                   run,
  input logic [CODE_W-1:0]      w0,
  input logic [CODE_W-1:0]      w1,
  input logic [(1<<CODE_W)-1:0] tap_sel0,
  input logic [(1<<CODE_W)-1:0] tap_sel1,
  input logic [1:0]             open_ends,
  input logic [1:0]             clamp_low
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W-1);

  // R5
  max_two_taps_chk: assert property (@(posedge clk) disable iff (!por_n)
    $countones(tap_sel0) <= 2 && $countones(tap_sel1) <= 2);

  // R7
  shut_opens_chk: assert property (@(posedge clk) disable iff (!por_n)
    !run |=> open_ends == 2'b11 && clamp_low == 2'b11);

  // R7
  open_no_tap_chk: assert property (@(posedge clk) disable iff (!por_n)
    open_ends[0] |-> tap_sel0 == '0);

  // R9
  clamp_release_tap_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(clamp_low[1]) |-> $countones(tap_sel1) == 1);

  // R10
  glitch_mid_chk: assert property (@(posedge clk) disable iff (!por_n)
    glitch && !run |=> w0 == MID && w1 == MID);
endmodule

bind dual_wiper_ctrl dual_wiper_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .por_n(por_n), .glitch(glitch), .run(run_q),
  .w0(wiper_q[0]), .w1(wiper_q[1]),
  .tap_sel0(tap_sel0), .tap_sel1(tap_sel1),
  .open_ends(open_ends), .clamp_low(clamp_low)
);

// File: tb/dual_wiper_ctrl_bench.sv
`timescale 1ns/1ps
module dual_wiper_ctrl_bench;
  localparam int OV = 4;
  localparam int ST = 6;

  logic         clk = 1'b0;
  logic         por_n = 1'b0;
  logic         glitch = 1'b0;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic [4:0]   rd_addr = '0;
  logic [7:0]   rd_data;
  logic [255:0] tap_sel0, tap_sel1;
  logic [1:0]   open_ends, clamp_low;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_wiper_ctrl #(.OVERLAP(OV), .SETTLE(ST)) u_dual_wiper_ctrl (
    .clk(clk), .por_n(por_n), .glitch(glitch), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tap_sel0(tap_sel0), .tap_sel1(tap_sel1),
    .open_ends(open_ends), .clamp_low(clamp_low)
  );

  typedef struct {
    int           kind;
    logic [255:0] exp;
    string        req;
  } item_t;

  item_t q[$];

  function automatic logic [255:0] oh(input int c);
    return 256'(1) << c;
  endfunction

  task automatic expect_item(input int kind, input logic [255:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [7:0] d, input string req);
    rd_addr = a;
    expect_item(0, 256'(d), req);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [255:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = 256'(rd_data);
        1: act = tap_sel0;
        2: act = tap_sel1;
        3: act = 256'(open_ends);
        default: act = 256'(clamp_low);
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    step(3);
    por_n = 1'b1;
    step(1);
    // R1 reset state
    rd_exp(5'h00, 8'h80, "R1"); step(1);
    rd_exp(5'h01, 8'h80, "R1"); step(1);
    rd_exp(5'h10, 8'h40, "R1");
    expect_item(1, oh(128), "R1"); expect_item(2, oh(128), "R1");
    expect_item(3, 0, "R1"); expect_item(4, 0, "R1");
    step(1);

    // R2 R4 R5: channel 0 to code 00h
    wr(5'h00, 8'h00);
    rd_exp(5'h00, 8'h00, "R2");
    step(1);
    expect_item(1, oh(128) | oh(0), "R5");
    expect_item(2, oh(128), "R5");
    step(OV - 1);
    expect_item(1, oh(128) | oh(0), "R5");
    step(1);
    expect_item(1, oh(0), "R4");

    // R6 queued write during overlap, R4 boundary FFh
    wr(5'h01, 8'hFF);
    step(1);
    expect_item(2, oh(128) | oh(255), "R5");
    wr(5'h01, 8'h40);
    rd_exp(5'h01, 8'h40, "R2");
    step(2);
    expect_item(2, oh(128) | oh(255), "R6");
    step(1);
    expect_item(2, oh(255), "R4");
    step(1);
    expect_item(2, oh(255) | oh(64), "R6");
    step(OV);
    expect_item(2, oh(64), "R6");

    // R3 control bits
    wr(5'h10, 8'hFF);
    rd_exp(5'h10, 8'h40, "R3");
    step(1);
    wr(5'h10, 8'hBF);
    rd_exp(5'h10, 8'h00, "R3");
    step(1);
    // R7 shutdown entry
    expect_item(1, 0, "R7"); expect_item(2, 0, "R7");
    expect_item(3, 256'(2'b11), "R7"); expect_item(4, 256'(2'b11), "R7");

    // R8 write in shutdown
    wr(5'h00, 8'h5A);
    rd_exp(5'h00, 8'h5A, "R8");
    step(3);
    expect_item(1, 0, "R8");

    // R2 unmapped address
    wr(5'h05, 8'h77);
    rd_exp(5'h05, 8'h00, "R2");
    step(1);
    rd_exp(5'h00, 8'h5A, "R2");
    step(1);

    // R10 glitch in shutdown beats a same-cycle write
    glitch = 1'b1; wr_en = 1'b1; wr_addr = 5'h01; wr_data = 8'h11;
    @(posedge clk); #1;
    glitch = 1'b0; wr_en = 1'b0;
    rd_exp(5'h00, 8'h80, "R10"); step(1);
    rd_exp(5'h01, 8'h80, "R10"); step(1);

    // R9 exit with settle
    wr(5'h00, 8'h21);
    wr(5'h10, 8'h40);
    step(1);
    expect_item(3, 0, "R9"); expect_item(4, 256'(2'b11), "R9");
    expect_item(1, 0, "R9");
    step(ST - 1);
    expect_item(4, 256'(2'b11), "R9"); expect_item(2, 0, "R9");
    step(1);
    expect_item(4, 0, "R9");
    expect_item(1, oh(33), "R9"); expect_item(2, oh(128), "R9");

    // R10 glitch while running is ignored
    step(1);
    glitch = 1'b1;
    step(1);
    glitch = 1'b0;
    rd_exp(5'h00, 8'h21, "R10");
    step(1);
    expect_item(1, oh(33), "R10");
    step(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule